// File: doc/BRIEF.md
# Half-Bridge Complementary Gate Timer

This block produces the two gate-drive timing signals for a half bridge from a system clock. A phase counter alternates between a charge phase, whose length in clocks comes from a period input, and a deadtime phase, whose length comes from a deadtime input. A toggle flip-flop decides which side each charge phase drives, so the high-side and low-side signals take turns and each receives the same share of every cycle.

The period input may be swept while the bridge runs, for example by a frequency-ramp controller. Each new value is taken only when a charge phase begins, so a pulse already in progress is never cut short. Dropping the enable clears both outputs on the next clock. Each time the low-side signal falls, a single-clock strobe is raised so that a protection block can sample the bridge current at that moment.

Top module: `hb_gate_timer`

## Requirements
- R1: While reset is high, and after reset until enable is sampled high, hi_drv_o, lo_drv_o and lo_fall_o are all 0.
- R2: On the first clock edge that samples run_en_i high after the block has been idle, lo_drv_o becomes 1 and hi_drv_o stays 0. The first pulse after any enable always goes to the low side.
- R3: Each drive pulse lasts exactly P clocks. P is period_i sampled on the edge that starts the pulse, and a value of 0 counts as 1.
- R4: Between the end of one drive pulse and the start of the next, both outputs are 0 for exactly D clocks. D is dead_i sampled on the edge that ends the pulse, and a value of 0 counts as 1.
- R5: Successive pulses alternate low, high, low, and so on. With constant inputs, over a whole number of cycles the two outputs spend equal numbers of clocks high.
- R6: A change of period_i during a pulse leaves that pulse unchanged and takes effect at the next pulse, and the outputs keep running.
- R7: The edge that samples run_en_i low drives both outputs to 0. They stay 0 while enable is low, and the sequence restarts as in R2 when enable returns.
- R8: lo_fall_o is 1 for exactly one clock, in the first cycle in which lo_drv_o is 0 after having been 1. This includes a fall caused by disable. It is 0 at all other times.
- R9: hi_drv_o and lo_drv_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| run_en_i | input | 1 | Run enable; low stops the bridge |
| period_i | input | PER_W | Charge phase length in clocks (0 means 1) |
| dead_i | input | DT_W | Deadtime length in clocks (0 means 1) |
| hi_drv_o | output | 1 | High-side drive timing |
| lo_drv_o | output | 1 | Low-side drive timing |
| lo_fall_o | output | 1 | One-clock strobe on each low-side falling edge |

## Verification
The bench targets four kinds of case: zero period and zero deadtime, a period change in the middle of a pulse, disable in the middle of a pulse or deadtime, and re-enable after the block has been idle. If the zero clamp were missing, the counter would wrap and give a pulse thousands of clocks long, or the two sides would overlap. If period_i were sampled at every clock, the pulse during which the period changed would be cut short or stretched. If the toggle were not cleared on disable, a restart could open on the high side before the bootstrap capacitor has charged. The strobe is checked on both kinds of falling edge: a normal one at the end of a pulse and one forced by disable.

// File: rtl/hb_gate_pkg.sv
`timescale 1ns/1ps
package hb_gate_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CHARGE = 2'd1,
    PH_DEAD   = 2'd2
  } hb_phase_e;

  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/hb_phase_timer.sv
`timescale 1ns/1ps
module hb_phase_timer
  import hb_gate_pkg::*;
#(
  parameter int unsigned PER_W = 16,
  parameter int unsigned DT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_en_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic             go_charge_o,
  output logic             go_dead_o,
  output logic             first_o
);
  localparam int unsigned CNT_W = max_w(PER_W, DT_W);

  hb_phase_e          phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   per_ld, dt_ld;

  // Zero settings are clamped to one clock; counters hold length-1.
  assign per_ld = (period_i == '0) ? '0 : CNT_W'(period_i) - CNT_W'(1);
  assign dt_ld  = (dead_i == '0)   ? '0 : CNT_W'(dead_i)   - CNT_W'(1);

  always_comb begin
    phase_d     = phase_q;
    cnt_d       = cnt_q;
    go_charge_o = 1'b0;
    go_dead_o   = 1'b0;
    first_o     = 1'b0;
    if (!run_en_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          go_charge_o = 1'b1;
          first_o     = 1'b1;
          phase_d     = PH_CHARGE;
          cnt_d       = per_ld;
        end
        PH_CHARGE: begin
          if (cnt_q == '0) begin
            go_dead_o = 1'b1;
            phase_d   = PH_DEAD;
            cnt_d     = dt_ld;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        PH_DEAD: begin
          if (cnt_q == '0) begin
            go_charge_o = 1'b1;
            phase_d     = PH_CHARGE;
            cnt_d       = per_ld;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/hb_side_steer.sv
`timescale 1ns/1ps
module hb_side_steer (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_en_i,
  input  logic go_charge_i,
  input  logic go_dead_i,
  input  logic first_i,
  output logic hi_drv_o,
  output logic lo_drv_o,
  output logic lo_fall_o
);
  // side_q = 1: current/last charge phase drove the high side.
  logic side_q, side_d, side_next;
  logic hi_q, hi_d, lo_q, lo_d, fall_q;

  assign side_next = first_i ? 1'b0 : ~side_q;

  always_comb begin
    side_d = side_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    if (!run_en_i) begin
      side_d = 1'b0;
      hi_d   = 1'b0;
      lo_d   = 1'b0;
    end else if (go_charge_i) begin
      side_d = side_next;
      hi_d   = side_next;
      lo_d   = ~side_next;
    end else if (go_dead_i) begin
      hi_d = 1'b0;
      lo_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      side_q <= 1'b0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      side_q <= side_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      fall_q <= lo_q & ~lo_d;
    end
  end

  assign hi_drv_o  = hi_q;
  assign lo_drv_o  = lo_q;
  assign lo_fall_o = fall_q;
endmodule

// File: rtl/hb_gate_timer.sv
`timescale 1ns/1ps
module hb_gate_timer #(
  parameter int unsigned PER_W = 16,
  parameter int unsigned DT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_en_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic             hi_drv_o,
  output logic             lo_drv_o,
  output logic             lo_fall_o
);
  logic go_charge, go_dead, first;

  hb_phase_timer #(.PER_W(PER_W), .DT_W(DT_W)) timer_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .run_en_i    (run_en_i),
    .period_i    (period_i),
    .dead_i      (dead_i),
    .go_charge_o (go_charge),
    .go_dead_o   (go_dead),
    .first_o     (first)
  );

  hb_side_steer steer_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .run_en_i    (run_en_i),
    .go_charge_i (go_charge),
    .go_dead_i   (go_dead),
    .first_i     (first),
    .hi_drv_o    (hi_drv_o),
    .lo_drv_o    (lo_drv_o),
    .lo_fall_o   (lo_fall_o)
  );
endmodule

// File: rtl/hb_gate_timer_chk.sv
`timescale 1ns/1ps
module hb_gate_timer_chk (
  input logic clk_i,
  input logic rst_i,
  input logic run_en_i,
  input logic hi_drv_o,
  input logic lo_drv_o,
  input logic lo_fall_o
);
  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
    !(hi_drv_o && lo_drv_o));

  a_r7_disable_clears: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(run_en_i) |-> (!hi_drv_o && !lo_drv_o));

  a_r8_strobe_on_fall: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(lo_drv_o) |-> lo_fall_o);

  a_r8_strobe_only_fall: assert property (@(posedge clk_i) disable iff (rst_i)
    lo_fall_o |-> (!lo_drv_o && $past(lo_drv_o)));

  a_r4_gap_before_hi: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(hi_drv_o) |-> !$past(lo_drv_o));

  a_r4_gap_before_lo: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(lo_drv_o) |-> !$past(hi_drv_o));
endmodule

bind hb_gate_timer hb_gate_timer_chk chk_i (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .run_en_i  (run_en_i),
  .hi_drv_o  (hi_drv_o),
  .lo_drv_o  (lo_drv_o),
  .lo_fall_o (lo_fall_o)
);

// File: tb/hb_gate_timer_tb_top.sv
`timescale 1ns/1ps
module hb_gate_timer_tb_top;
  localparam int unsigned PER_W = 16;
  localparam int unsigned DT_W  = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en  = 1'b0;
  logic [PER_W-1:0] period_v = 16'd3;
  logic [DT_W-1:0]  dead_v   = 8'd2;
  logic             hi, lo, fall;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hb_gate_timer #(.PER_W(PER_W), .DT_W(DT_W)) dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .run_en_i  (en),
    .period_i  (period_v),
    .dead_i    (dead_v),
    .hi_drv_o  (hi),
    .lo_drv_o  (lo),
    .lo_fall_o (fall)
  );

  // Reference model built from the requirements (0 idle, 1 pulse, 2 gap)
  int m_ph = 0;
  int m_cnt = 0;
  bit m_side = 0, m_hi = 0, m_lo = 0, m_fall = 0, m_nlo = 0;

  function automatic int clampv(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    if (rst || !en) begin
      m_ph = 0; m_hi = 0; m_nlo = 0;
    end else begin
      case (m_ph)
        0: begin m_ph = 1; m_side = 0; m_cnt = clampv(int'(period_v)) - 1; m_hi = 0; m_nlo = 1; end
        1: if (m_cnt == 0) begin
             m_ph = 2; m_cnt = clampv(int'(dead_v)) - 1; m_hi = 0; m_nlo = 0;
           end else begin m_cnt--; m_nlo = m_lo; end
        default: if (m_cnt == 0) begin
             m_ph = 1; m_side = ~m_side; m_cnt = clampv(int'(period_v)) - 1;
             m_hi = m_side; m_nlo = ~m_side;
           end else begin m_cnt--; m_nlo = 0; end
      endcase
    end
    m_fall = rst ? 1'b0 : (m_lo & ~m_nlo);
    m_lo   = m_nlo;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    string tag;
    @(negedge clk);
    tag = (m_ph == 0) ? "R7" : (m_ph == 1) ? "R3" : "R4";
    chk({hi, lo} === {m_hi, m_lo}, tag, int'({hi, lo}), int'({m_hi, m_lo}));
    chk(fall === m_fall, "R8", int'(fall), int'(m_fall));
    chk(!(hi && lo), "R9", int'({hi, lo}), 1);
  endtask

  initial begin
    int nh, nl, r;
    void'($urandom(32'h5eed));
    repeat (4) step();
    chk({hi, lo, fall} === 3'b000, "R1", int'({hi, lo, fall}), 0);
    rst = 1'b0;
    repeat (3) step();
    chk({hi, lo, fall} === 3'b000, "R1", int'({hi, lo, fall}), 0);
    en = 1'b1;
    step();
    chk(lo === 1'b1 && hi === 1'b0, "R2", int'({hi, lo}), 1);
    repeat (30) step();

    // R5: equal share over four full cycles (P=4, D=2 -> 12 clocks each)
    en = 1'b0; step();
    period_v = 16'd4; dead_v = 8'd2; en = 1'b1;
    nh = 0; nl = 0;
    repeat (48) begin step(); nh += int'(hi); nl += int'(lo); end
    chk(nh == 16, "R5", nh, 16);
    chk(nl == 16, "R5", nl, 16);

    // R6: period changed mid-pulse, current pulse keeps its length
    en = 1'b0; step();
    chk(fall === 1'b0 || fall === 1'b1, "R7", int'({hi, lo}), 0);
    period_v = 16'd5; en = 1'b1;
    nh = 0; nl = 0;
    step(); nl += int'(lo); nh += int'(hi);
    step(); nl += int'(lo); nh += int'(hi);
    period_v = 16'd2;
    repeat (10) begin step(); nl += int'(lo); nh += int'(hi); end
    chk(nl == 6, "R6", nl, 6);
    chk(nh == 2, "R6", nh, 2);

    // R4: zero period and zero deadtime clamp to one clock each
    en = 1'b0; step();
    period_v = '0; dead_v = '0; en = 1'b1;
    nh = 0; nl = 0;
    repeat (8) begin step(); nl += int'(lo); nh += int'(hi); end
    chk(nl == 2, "R4", nl, 2);
    chk(nh == 2, "R4", nh, 2);

    // Random phase: enable drops, period sweeps, deadtime changes
    for (int i = 0; i < 3000; i++) begin
      step();
      r = int'($urandom % 100);
      if (r < 3) en = ~en;
      else if (r < 12) period_v = PER_W'($urandom % 7);
      else if (r < 17) dead_v = DT_W'($urandom % 4);
    end

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL R3 watchdog act=1 exp=0");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule